// File: doc/BRIEF.md
# Periodic Interval Timer

The block is a memory-mapped timer that produces a regular time base for software. A fixed divide-by-16 prescaler turns the system clock into a slow tick. On every tick an interval counter steps upward from zero, and when it reaches a programmed limit it returns to zero. Each return to zero is counted in a saturating overflow counter and sets a sticky status flag. When the interrupt enable is set, that flag drives an interrupt line.

Software sees four 32-bit registers through a single-cycle read/write strobe interface. One register holds the mode, one holds the status, and two views show the same packed counter state. Reading the acknowledging view returns the state and then clears both the overflow count and the flag. Reading the plain view has no side effect, so a free-running clock source can sample the time without disturbing interrupt bookkeeping. Clearing the enable bit does not halt the timer at once. The current interval runs to its end, the counter comes to rest at zero, and software can poll for that zero before it reprograms the timer.

Top module: `pit_timer`

## Requirements
- R1: After reset every register reads as zero and `irq` is low.
- R2: The register is chosen by `addr[3:2]`: 0x0 is mode, 0x4 is status, 0x8 is the acknowledging value and 0xC is the plain value. In mode, bits 19:0 hold the period minus one, bit 24 is enable and bit 25 is interrupt enable, and mode reads back as written. Read data appears on `rdata` after the clock edge that samples `rd_en`.
- R3: The interval counter advances once every 16 clocks. After a mode write sets enable from a stopped state, the first increment lands 16 clocks after the write edge.
- R4: The interval counter counts 0, 1, …, limit and then returns to 0. Each such wrap adds one to the overflow count.
- R5: Both value registers pack the overflow count in bits 31:20 and the interval count in bits 19:0.
- R6: A read at 0x8 returns the state as it stood before the read, and then clears the overflow count and the status flag.
- R7: A read at 0xC returns the same packed value and changes nothing.
- R8: Status bit 0 is a flag that each wrap sets.
- R9: `irq` is high only while the flag and the interrupt enable are both set. Clearing the interrupt enable leaves counting untouched.
- R10: When enable is cleared, the counter finishes the current interval, wraps to 0 (and counts that wrap), and then stays at 0.
- R11: A mode write that changes the limit while the timer runs takes effect at the next wrap. The interval in progress ends at the old limit.
- R12: The overflow count saturates at 4095.
- R13: If a wrap and an acknowledging read fall on the same edge, the read returns the earlier state, and afterwards the overflow count is 1 and the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following:
- the interval counter only steps by one or returns to zero;
- a wrap always leaves the counter at zero and the flag set;
- a stopped counter stays at zero;
- the interrupt never rises without the flag;
- the effect of an acknowledging read on the overflow count and flag, both with and without a wrap on the same edge;
- the saturated overflow count holds.

The bench scenarios cover what depends on exact timing and on software-visible values: the 16-clock tick spacing from start, the packed read values at chosen points in the count, the absence of side effects on plain reads, the delayed effect of a new limit, the soft stop, and saturation after more than 4095 wraps.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int unsigned PIT_PER_W  = 20;
  localparam int unsigned PIT_OVF_W  = 12;
  localparam int unsigned PIT_DATA_W = 32;
  localparam int unsigned PIT_EN_BIT = 24;
  localparam int unsigned PIT_IE_BIT = 25;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_VACK = 2'd2,
    SEL_VRAW = 2'd3
  } pit_sel_e;

endpackage

// File: rtl/pit_prescale.sv
module pit_prescale #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = run;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (clr || !run) begin
          cnt_d = '0;
        end else if (cnt_q == LAST) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign tick = run && (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int unsigned PER_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             start,
  input  logic [PER_W-1:0] start_per,
  input  logic [PER_W-1:0] mode_per,
  output logic [PER_W-1:0] cur,
  output logic             wrap,
  output logic             run
);

  logic [PER_W-1:0] cur_q;
  logic [PER_W-1:0] cur_d;
  logic [PER_W-1:0] lim_q;
  logic [PER_W-1:0] lim_d;
  logic             cur_ce;
  logic             lim_ce;

  assign run  = en || (cur_q != '0);
  assign wrap = tick && (cur_q >= lim_q);

  // interval counter
  assign cur_ce = tick;
  always_comb begin
    cur_d = cur_q;
    if (wrap) begin
      cur_d = '0;
    end else begin
      cur_d = cur_q + 1'b1;
    end
  end

  // active limit: reloaded on start, on wrap, or while idle
  assign lim_ce = start || wrap || !run;
  always_comb begin
    lim_d = lim_q;
    if (start) begin
      lim_d = start_per;
    end else begin
      lim_d = mode_per;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      lim_q <= '0;
    end else begin
      if (cur_ce) begin
        cur_q <= cur_d;
      end
      if (lim_ce) begin
        lim_q <= lim_d;
      end
    end
  end

  assign cur = cur_q;

endmodule

// File: rtl/pit_ovf.sv
module pit_ovf #(
  parameter int unsigned OVF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             ack,
  output logic [OVF_W-1:0] ovf,
  output logic             flag
);

  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  logic [OVF_W-1:0] ovf_q;
  logic [OVF_W-1:0] ovf_d;
  logic             flag_q;
  logic             flag_d;

  always_comb begin
    ovf_d  = ovf_q;
    flag_d = flag_q;
    if (ack) begin
      ovf_d  = wrap ? OVF_W'(1) : '0;
      flag_d = wrap;
    end else if (wrap) begin
      flag_d = 1'b1;
      if (ovf_q != OVF_MAX) begin
        ovf_d = ovf_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= '0;
      flag_q <= 1'b0;
    end else if (ack || wrap) begin
      ovf_q  <= ovf_d;
      flag_q <= flag_d;
    end
  end

  assign ovf  = ovf_q;
  assign flag = flag_q;

endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PER_W  = 20,
  parameter int unsigned OVF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PER_W-1:0]  cur,
  input  logic [OVF_W-1:0]  ovf,
  input  logic              flag,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic              ie,
  output logic [PER_W-1:0]  mode_per,
  output logic              start,
  output logic [PER_W-1:0]  start_per,
  output logic              ack,
  output logic              irq
);

  pit_sel_e          sel;
  logic              mode_we;
  logic [PER_W-1:0]  per_q;
  logic              en_q;
  logic              ie_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] value_w;
  logic [DATA_W-1:0] mode_w;

  assign sel     = pit_sel_e'(addr[3:2]);
  assign mode_we = wr_en && (sel == SEL_MODE);
  assign ack     = rd_en && (sel == SEL_VACK);

  // enable rising from a write restarts the prescaler and loads the limit
  assign start     = mode_we && wdata[PIT_EN_BIT] && !en_q;
  assign start_per = wdata[PER_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      en_q  <= 1'b0;
      ie_q  <= 1'b0;
    end else if (mode_we) begin
      per_q <= wdata[PER_W-1:0];
      en_q  <= wdata[PIT_EN_BIT];
      ie_q  <= wdata[PIT_IE_BIT];
    end
  end

  always_comb begin
    value_w                      = '0;
    value_w[PER_W-1:0]           = cur;
    value_w[DATA_W-1 -: OVF_W]   = ovf;
    mode_w                       = '0;
    mode_w[PER_W-1:0]            = per_q;
    mode_w[PIT_EN_BIT]           = en_q;
    mode_w[PIT_IE_BIT]           = ie_q;
  end

  always_comb begin
    rdata_d = '0;
    unique case (sel)
      SEL_MODE: rdata_d = mode_w;
      SEL_STAT: rdata_d = {{(DATA_W-1){1'b0}}, flag};
      SEL_VACK: rdata_d = value_w;
      SEL_VRAW: rdata_d = value_w;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata    = rdata_q;
  assign en       = en_q;
  assign ie       = ie_q;
  assign mode_per = per_q;
  assign irq      = flag && ie_q;

endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = PIT_DATA_W,
  parameter int unsigned PER_W    = PIT_PER_W,
  parameter int unsigned OVF_W    = PIT_OVF_W,
  parameter int unsigned PRESCALE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic             rst_meta_n;
  logic             rst_sync_n;
  logic             tick_w;
  logic             run_w;
  logic             wrap_w;
  logic             en_w;
  logic             ie_w;
  logic             start_w;
  logic             ack_w;
  logic             flag_w;
  logic [PER_W-1:0] cur_w;
  logic [PER_W-1:0] mode_per_w;
  logic [PER_W-1:0] start_per_w;
  logic [OVF_W-1:0] ovf_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  pit_prescale #(.DIV(PRESCALE)) i_prescale (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (start_w),
    .run   (run_w),
    .tick  (tick_w)
  );

  pit_counter #(.PER_W(PER_W)) i_counter (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick_w),
    .en        (en_w),
    .start     (start_w),
    .start_per (start_per_w),
    .mode_per  (mode_per_w),
    .cur       (cur_w),
    .wrap      (wrap_w),
    .run       (run_w)
  );

  pit_ovf #(.OVF_W(OVF_W)) i_ovf (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wrap  (wrap_w),
    .ack   (ack_w),
    .ovf   (ovf_w),
    .flag  (flag_w)
  );

  pit_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PER_W  (PER_W),
    .OVF_W  (OVF_W)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .cur       (cur_w),
    .ovf       (ovf_w),
    .flag      (flag_w),
    .rdata     (rdata),
    .en        (en_w),
    .ie        (ie_w),
    .mode_per  (mode_per_w),
    .start     (start_w),
    .start_per (start_per_w),
    .ack       (ack_w),
    .irq       (irq)
  );

endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int unsigned PER_W = 20,
  parameter int unsigned OVF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             ack,
  input logic             wrap,
  input logic             en,
  input logic             flag,
  input logic [PER_W-1:0] cur,
  input logic [OVF_W-1:0] ovf
);

  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag); // R9

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cur == '0)); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur) |-> ((cur == PER_W'($past(cur) + 1'b1)) || (cur == '0))); // R4

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag); // R8

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && (cur == '0)) |=> (cur == '0)); // R10

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wrap) |=> ((ovf == '0) && !flag)); // R6

  AST_ACK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && wrap) |=> ((ovf == OVF_W'(1)) && flag)); // R13

  AST_OVF_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf == OVF_MAX) && !ack) |=> (ovf == OVF_MAX)); // R12

endmodule

bind pit_timer pit_checker #(
  .PER_W (PER_W),
  .OVF_W (OVF_W)
) i_pit_checker (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .irq   (irq),
  .ack   (ack_w),
  .wrap  (wrap_w),
  .en    (en_w),
  .flag  (flag_w),
  .cur   (cur_w),
  .ovf   (ovf_w)
);

// File: tb/test_pit_timer.sv
`timescale 1ns/1ps
module test_pit_timer;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_VACK = 2'd2;
  localparam logic [1:0] A_VRAW = 2'd3;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int cyc;
  logic rd_seen;
  int mon_checks;
  int mon_errs;
  int dir_checks;
  int dir_errs;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  pit_timer i_pit_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  initial rd_seen = 1'b0;
  always @(posedge clk) rd_seen <= rd_en;

  function automatic logic [31:0] mk(int per, bit en, bit ie);
    return 32'(per) | (32'(en) << 24) | (32'(ie) << 25);
  endfunction

  function automatic logic [31:0] pk(int o, int c);
    return (32'(o) << 20) | 32'(c);
  endfunction

  // monitor: compares each read result with the expected item queued by the driver
  initial begin
    mon_checks = 0;
    mon_errs   = 0;
  end
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        mon_errs = mon_errs + 1;
        $display("FAIL monitor: read result with no expected item, actual %h", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        mon_checks = mon_checks + 1;
        if (rdata !== e) begin
          mon_errs = mon_errs + 1;
          $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic sync_to(int e);
    @(negedge clk);
    while (cyc < e - 1) @(negedge clk);
  endtask

  task automatic do_read(int e, logic [1:0] sel, logic [31:0] exp, string tag);
    sync_to(e);
    rd_en = 1'b1;
    addr  = {sel, 2'b00};
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(int e, logic [31:0] d, output int edge_o);
    sync_to(e);
    wr_en = 1'b1;
    addr  = 4'h0;
    wdata = d;
    edge_o = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_bit(logic act, logic exp, string tag);
    dir_checks = dir_checks + 1;
    if (act !== exp) begin
      dir_errs = dir_errs + 1;
      $display("FAIL %s: irq actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic report(int extra);
    $display("Simulation finished: %0d checks, %0d errors",
             mon_checks + dir_checks + extra, mon_errs + dir_errs + extra);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    report(1);
  end

  initial begin
    int t0;
    int t1;
    int t2;
    int d;
    dir_checks = 0;
    dir_errs   = 0;
    rst_n = 1'b0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    addr  = 4'h0;
    wdata = 32'h0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk_bit(irq, 1'b0, "R1 irq after reset");
    do_read(0, A_MODE, 32'h0, "R1 mode after reset");
    do_read(0, A_STAT, 32'h0, "R1 status after reset");
    do_read(0, A_VRAW, 32'h0, "R1 value after reset");
    do_read(0, A_VACK, 32'h0, "R1 ack value after reset");

    // limit 4 -> five ticks per interval; after edge t0+16k: cur=k%5, wraps=k/5
    do_write(0, mk(4, 1'b1, 1'b0), t0);
    do_read(t0 + 16*12 + 8,  A_VRAW, pk(2, 2), "R3 R4 R5 count and overflows");
    do_read(t0 + 16*12 + 11, A_VRAW, pk(2, 2), "R7 plain read repeated");
    do_read(t0 + 16*12 + 14, A_STAT, 32'h1,    "R8 flag after wraps");
    chk_bit(irq, 1'b0, "R9 irq masked while ie clear");
    do_read(t0 + 16*13 + 8,  A_VACK, pk(2, 3), "R6 ack returns prior state");
    do_read(t0 + 16*14 + 8,  A_VRAW, pk(0, 4), "R6 overflow cleared by ack");
    do_read(t0 + 16*14 + 11, A_STAT, 32'h0,    "R6 flag cleared by ack");

    // R13: ack on the wrap edge
    do_read(t0 + 16*15,      A_VACK, pk(0, 4), "R13 ack on wrap edge returns prior");
    do_read(t0 + 16*15 + 8,  A_VRAW, pk(1, 0), "R13 overflow kept as one");
    do_read(t0 + 16*15 + 11, A_STAT, 32'h1,    "R13 flag kept");

    // R9: interrupt enable
    do_write(t0 + 16*16 + 8, mk(4, 1'b1, 1'b1), d);
    chk_bit(irq, 1'b1, "R9 irq with flag and ie");
    do_read(t0 + 16*16 + 12, A_MODE, mk(4, 1'b1, 1'b1), "R2 mode readback");
    do_read(t0 + 16*17 + 8,  A_VACK, pk(1, 2), "R6 ack with ie set");
    chk_bit(irq, 1'b0, "R9 irq drops after ack");
    do_write(t0 + 16*18 + 8, mk(4, 1'b1, 1'b0), d);
    do_read(t0 + 16*21 + 8,  A_VRAW, pk(1, 1), "R9 counting continues with ie clear");
    do_read(t0 + 16*21 + 11, A_STAT, 32'h1,    "R9 flag set by later wrap");
    chk_bit(irq, 1'b0, "R9 irq masked after ie cleared");

    // R10: soft stop
    do_write(t0 + 16*22 + 8, mk(4, 1'b0, 1'b0), d);
    do_read(t0 + 16*24 + 8,  A_VRAW, pk(1, 4), "R10 interval finishes after disable");
    do_read(t0 + 16*30 + 8,  A_VRAW, pk(2, 0), "R10 final wrap counted, rests at zero");
    do_read(t0 + 16*40 + 8,  A_VRAW, pk(2, 0), "R10 stays at zero");
    do_read(t0 + 16*41 + 8,  A_VACK, pk(2, 0), "R6 ack while stopped");

    // limit 2 from stopped, then limit 7 while running
    do_write(0, mk(2, 1'b1, 1'b0), t1);
    do_read(t1 + 16,         A_VRAW, pk(0, 0), "R3 no step before 16 clocks");
    do_read(t1 + 18,         A_VRAW, pk(0, 1), "R3 first step at 16 clocks");
    do_write(t1 + 16*4 + 5, mk(7, 1'b1, 1'b0), d);
    do_read(t1 + 16*5 + 8,   A_VRAW, pk(1, 2), "R11 old limit still in use");
    do_read(t1 + 16*6 + 8,   A_VRAW, pk(2, 0), "R11 wrap at old limit");
    do_read(t1 + 16*13 + 8,  A_VRAW, pk(2, 7), "R11 new limit after wrap");
    do_read(t1 + 16*14 + 8,  A_VRAW, pk(3, 0), "R4 wrap at new limit");

    // R12: saturation with limit 0 (wrap on every tick)
    do_write(t1 + 16*14 + 12, mk(0, 1'b0, 1'b0), d);
    do_read(0, A_VACK, pk(3, 0), "R6 ack before saturation run");
    do_write(0, mk(0, 1'b1, 1'b0), t2);
    do_read(t2 + 16*4100 + 8, A_VRAW, pk(4095, 0), "R12 overflow saturates");

    repeat (3) @(negedge clk);
    report(0);
  end

endmodule